// File: doc/BRIEF.md
# Multi-Channel DMA Command-Port Register File

This block is the programming front end of a bus DMA controller with up to sixteen channels. Software reaches it through two byte-wide ports. A write to the command port packs an operation code in the upper nibble and a channel number in the lower nibble. Any bytes that operation needs then pass through the execute port, one byte per access, from least significant to most significant. A byte pointer steps through those bytes, and every new command sets it back to zero.

Each channel holds five values: a 16-bit I/O port number, a 24-bit memory address, a 16-bit count that stores the transfer length minus one, a mode byte and a mask bit. The address and the remaining count can be read back through the execute port. A per-channel `armed` vector tells the transfer engine which channels it may service. A configuration view port shows the full register set of any one channel. A single-step input takes the place of the real engine: each step moves an armed channel forward by one transfer unit.

Top module: `dma_cmd_regfile`

## Requirements
- R1: After reset every channel is masked, its address, count, port and mode are zero, `armed` is all zero, and no operation is selected, so execute-port writes change nothing until a command arrives.
- R2: A command byte selects the operation with bits 7:4 and the channel with bits 3:0. Code 0x9 masks the channel and code 0xA unmasks it. Both take effect on the clock edge that accepts the command.
- R3: After command code 0x2, three execute writes load address bits 7:0, then 15:8, then 23:16.
- R4: After command code 0x4, two execute writes load count bits 7:0 and then 15:8. The stored value is the transfer length minus one.
- R5: After command code 0x0, two execute writes load the I/O port number, low byte first.
- R6: After command code 0x7, one execute write loads the mode byte. Bit 2 is transfer enable, bit 3 is read direction, bit 0 is I/O-register target and bit 6 is 16-bit width. A channel's `armed` bit is high exactly when the channel is unmasked and its mode bit 2 is set.
- R7: Execute writes beyond the byte count of the current operation are ignored, as are execute writes under a read, mask, unmask or unassigned code. Any command write returns the byte pointer to zero. A command write in the same cycle as an execute access wins.
- R8: After code 0x3 (3 bytes of address) or code 0x5 (2 bytes of remaining count), `exe_rbyte` presents the byte at the pointer, low byte first. Each `exe_re` advances the pointer. Past the last byte, and under every other code, `exe_rbyte` is 0x00.
- R9: A step (`step_en`, channel `step_ch`) in a cycle with no command or execute write acts only on an armed channel whose count is non-zero. It lowers the count by one and raises the address by 2 when mode bit 6 is set, or by 1 otherwise, wrapping at 24 bits. A masked or disarmed channel, or one whose count is zero, does not change.
- R10: Programming one channel never changes the registers of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command-port write strobe |
| cmd_byte | input | 8 | Command byte: opcode in 7:4, channel in 3:0 |
| exe_we | input | 1 | Execute-port write strobe |
| exe_wbyte | input | 8 | Execute-port write data |
| exe_re | input | 1 | Execute-port read strobe (advances the pointer) |
| exe_rbyte | output | 8 | Execute-port read data at the current pointer |
| step_en | input | 1 | Single-step request from the engine model |
| step_ch | input | CH_W | Channel to step |
| armed | output | NCH | Per-channel armed flags |
| cfg_ch | input | CH_W | Channel shown on the configuration view |
| cfg_addr | output | 24 | Address of the viewed channel |
| cfg_count | output | 16 | Count of the viewed channel |
| cfg_port | output | 16 | I/O port number of the viewed channel |
| cfg_mode | output | 8 | Mode byte of the viewed channel |
| cfg_masked | output | 1 | Mask bit of the viewed channel |

## Verification
The bench attacks pointer handling. It sends surplus execute bytes, reissues a command halfway through a load, and reads past the last byte of a read-back. A design that failed to reset or bound its pointer would overwrite high address bytes or return stale data. Steps are aimed at masked channels, at channels whose count is zero and at cycles that also carry a command. A wrong gate there would move the count or address of a channel that must stay frozen. The step test also runs an address across the 24-bit wrap and compares 8-bit against 16-bit steps, which catches an increment of the wrong size. A long pseudo-random phase watches other channels for cross-writes.

// File: rtl/dma_cmd_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the DMA command-port register file.
// Assumes an 8-bit command byte: opcode in the upper nibble, channel in the lower.
package dma_cmd_pkg;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int PORT_W = 16;

    localparam logic [3:0] OP_SET_PORT = 4'h0;
    localparam logic [3:0] OP_SET_ADDR = 4'h2;
    localparam logic [3:0] OP_GET_ADDR = 4'h3;
    localparam logic [3:0] OP_SET_CNT  = 4'h4;
    localparam logic [3:0] OP_GET_CNT  = 4'h5;
    localparam logic [3:0] OP_SET_MODE = 4'h7;
    localparam logic [3:0] OP_MASK     = 4'h9;
    localparam logic [3:0] OP_UNMASK   = 4'hA;
    localparam logic [3:0] OP_NONE     = 4'hF;

    localparam int MODE_IO_BIT   = 0;
    localparam int MODE_EN_BIT   = 2;
    localparam int MODE_RD_BIT   = 3;
    localparam int MODE_WIDE_BIT = 6;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic [PORT_W-1:0] port;
        logic [7:0]        mode;
        logic              masked;
    } chan_cfg_t;

    // Number of execute-port bytes an operation moves.
    function automatic logic [1:0] op_bytes(input logic [3:0] op);
        case (op)
            OP_SET_PORT, OP_SET_CNT, OP_GET_CNT: op_bytes = 2'd2;
            OP_SET_ADDR, OP_GET_ADDR:            op_bytes = 2'd3;
            OP_SET_MODE:                         op_bytes = 2'd1;
            default:                             op_bytes = 2'd0;
        endcase
    endfunction

    function automatic logic op_is_load(input logic [3:0] op);
        op_is_load = (op == OP_SET_PORT) || (op == OP_SET_ADDR) ||
                     (op == OP_SET_CNT)  || (op == OP_SET_MODE);
    endfunction

    function automatic logic op_is_fetch(input logic [3:0] op);
        op_is_fetch = (op == OP_GET_ADDR) || (op == OP_GET_CNT);
    endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
`timescale 1ns/1ps
// Command latch and execute-port byte pointer.
// Holds the last accepted opcode and channel, and steps the pointer through
// the bytes of that operation. Assumes a command write outranks execute access.
module dma_cmd_decode
    import dma_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic       exe_we,
    input  logic       exe_re,
    output logic [3:0] cur_op,
    output logic [3:0] cur_ch,
    output logic [1:0] ptr,
    output logic       wr_fire
);
    logic       in_range;
    logic       rd_adv;

    // Byte pointer still inside the current operation.
    assign in_range = ptr < op_bytes(cur_op);
    assign wr_fire  = exe_we && !cmd_we && op_is_load(cur_op) && in_range;
    assign rd_adv   = exe_re && !exe_we && !cmd_we && op_is_fetch(cur_op) && in_range;

    // Latch command fields and advance the pointer on accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_op <= OP_NONE;
            cur_ch <= '0;
            ptr    <= '0;
        end else if (cmd_we) begin
            cur_op <= cmd_byte[7:4];
            cur_ch <= cmd_byte[3:0];
            ptr    <= '0;
        end else if (wr_fire || rd_adv) begin
            ptr    <= ptr + 2'd1;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
// Register set of one DMA channel with a single-step count model.
// Assumes the parent has already qualified every strobe for this channel.
// Mask changes outrank byte loads, and byte loads outrank a step.
module dma_chan_regs
    import dma_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_hit,
    input  logic       unmask_hit,
    input  logic       wr_hit,
    input  logic [3:0] op,
    input  logic [1:0] ptr,
    input  logic [7:0] wbyte,
    input  logic       step_hit,
    output chan_cfg_t  cfg,
    output logic       armed
);
    // Channel may be serviced: unmasked and transfer enabled.
    assign armed = !cfg.masked && cfg.mode[MODE_EN_BIT];

    // Register updates: reset, mask changes, byte loads, then the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg.masked <= 1'b1;
        end else if (mask_hit) begin
            cfg.masked <= 1'b1;
        end else if (unmask_hit) begin
            cfg.masked <= 1'b0;
        end else if (wr_hit) begin
            case (op)
                OP_SET_PORT: begin
                    if (ptr == 2'd0) cfg.port[7:0]  <= wbyte;
                    else             cfg.port[15:8] <= wbyte;
                end
                OP_SET_ADDR: begin
                    case (ptr)
                        2'd0:    cfg.addr[7:0]   <= wbyte;
                        2'd1:    cfg.addr[15:8]  <= wbyte;
                        default: cfg.addr[23:16] <= wbyte;
                    endcase
                end
                OP_SET_CNT: begin
                    if (ptr == 2'd0) cfg.count[7:0]  <= wbyte;
                    else             cfg.count[15:8] <= wbyte;
                end
                OP_SET_MODE: cfg.mode <= wbyte;
                default: ;
            endcase
        end else if (step_hit && armed && (cfg.count != '0)) begin
            cfg.count <= cfg.count - 1'b1;
            cfg.addr  <= cfg.addr + (cfg.mode[MODE_WIDE_BIT] ? 24'd2 : 24'd1);
        end
    end
endmodule

// File: rtl/dma_cmd_regfile.sv
`timescale 1ns/1ps
// Multi-channel DMA command-port register file (top).
// Decodes the command and execute byte ports, holds NCH channel register
// sets, serves address and count read-back, and exposes per-channel armed
// flags plus a view of one channel's full configuration.
// Assumes NCH <= 16, since the command byte carries a 4-bit channel.
module dma_cmd_regfile
    import dma_cmd_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_byte,
    input  logic              exe_we,
    input  logic [7:0]        exe_wbyte,
    input  logic              exe_re,
    output logic [7:0]        exe_rbyte,
    input  logic              step_en,
    input  logic [CH_W-1:0]   step_ch,
    output logic [NCH-1:0]    armed,
    input  logic [CH_W-1:0]   cfg_ch,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [CNT_W-1:0]  cfg_count,
    output logic [PORT_W-1:0] cfg_port,
    output logic [7:0]        cfg_mode,
    output logic              cfg_masked
);
    logic [3:0]            cur_op;
    logic [3:0]            cur_ch;
    logic [1:0]            ptr;
    logic                  wr_fire;
    logic                  quiet;
    chan_cfg_t             cfg_q [NCH];
    chan_cfg_t             rd_src;
    chan_cfg_t             view;
    logic [NCH-1:0]        chan_masked;
    logic [NCH-1:0][15:0]  chan_count;

    dma_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_byte (cmd_byte),
        .exe_we   (exe_we),
        .exe_re   (exe_re),
        .cur_op   (cur_op),
        .cur_ch   (cur_ch),
        .ptr      (ptr),
        .wr_fire  (wr_fire)
    );

    // A step applies only in a cycle with no register traffic.
    assign quiet = !cmd_we && !exe_we;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_chan_regs u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_hit   (cmd_we && cmd_byte[7:4] == OP_MASK   && cmd_byte[3:0] == 4'(i)),
            .unmask_hit (cmd_we && cmd_byte[7:4] == OP_UNMASK && cmd_byte[3:0] == 4'(i)),
            .wr_hit     (wr_fire && cur_ch == 4'(i)),
            .op         (cur_op),
            .ptr        (ptr),
            .wbyte      (exe_wbyte),
            .step_hit   (step_en && quiet && step_ch == CH_W'(i)),
            .cfg        (cfg_q[i]),
            .armed      (armed[i])
        );
        assign chan_masked[i] = cfg_q[i].masked;
        assign chan_count[i]  = cfg_q[i].count;
    end

    // Select the channel named by the latched command and by the view port.
    always_comb begin
        rd_src = '0;
        view   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cur_ch == 4'(i))   rd_src = cfg_q[i];
            if (cfg_ch == CH_W'(i)) view  = cfg_q[i];
        end
    end

    // Read-back byte at the pointer, zero outside a valid fetch.
    always_comb begin
        exe_rbyte = 8'h00;
        if (cur_op == OP_GET_ADDR) begin
            case (ptr)
                2'd0:    exe_rbyte = rd_src.addr[7:0];
                2'd1:    exe_rbyte = rd_src.addr[15:8];
                2'd2:    exe_rbyte = rd_src.addr[23:16];
                default: exe_rbyte = 8'h00;
            endcase
        end else if (cur_op == OP_GET_CNT) begin
            case (ptr)
                2'd0:    exe_rbyte = rd_src.count[7:0];
                2'd1:    exe_rbyte = rd_src.count[15:8];
                default: exe_rbyte = 8'h00;
            endcase
        end
    end

    assign cfg_addr   = view.addr;
    assign cfg_count  = view.count;
    assign cfg_port   = view.port;
    assign cfg_mode   = view.mode;
    assign cfg_masked = view.masked;
endmodule

// File: rtl/dma_cmd_regfile_chk.sv
`timescale 1ns/1ps
// Property checker for dma_cmd_regfile, attached by bind.
// Watches mask and unmask commands, the armed flags and the step model.
module dma_cmd_regfile_chk #(
    parameter int NCH = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_we,
    input logic [7:0]           cmd_byte,
    input logic                 exe_we,
    input logic                 step_en,
    input logic [CH_W-1:0]      step_ch,
    input logic [NCH-1:0]       armed,
    input logic [NCH-1:0]       chan_masked,
    input logic [NCH-1:0][15:0] chan_count
);
    // R1: first cycle out of reset has all channels masked and none armed.
    p_reset_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (armed == '0 && (&chan_masked)));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R2: mask command sets the mask bit on the next edge.
        p_mask_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_we && cmd_byte == {4'h9, 4'(i)}) |=> chan_masked[i]);
        // R2: unmask command clears it.
        p_unmask_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_we && cmd_byte == {4'hA, 4'(i)}) |=> !chan_masked[i]);
        // R6: an armed channel is never masked.
        p_armed_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            armed[i] |-> !chan_masked[i]);
        // R9: a step on a masked channel leaves its count alone.
        p_step_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && step_ch == CH_W'(i) && chan_masked[i] && !cmd_we && !exe_we)
            |=> $stable(chan_count[i]));
        // R9: a step on an armed channel with count left lowers it by one.
        p_step_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && step_ch == CH_W'(i) && armed[i] && chan_count[i] != 16'd0
             && !cmd_we && !exe_we)
            |=> chan_count[i] == $past(chan_count[i]) - 16'd1);
    end
endmodule

bind dma_cmd_regfile dma_cmd_regfile_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_byte    (cmd_byte),
    .exe_we      (exe_we),
    .step_en     (step_en),
    .step_ch     (step_ch),
    .armed       (armed),
    .chan_masked (chan_masked),
    .chan_count  (chan_count)
);

// File: tb/dma_cmd_regfile_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the design every clock.
module dma_cmd_regfile_bench;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        exe_we = 1'b0;
    logic [7:0]  exe_wbyte = '0;
    logic        exe_re = 1'b0;
    logic [7:0]  exe_rbyte;
    logic        step_en = 1'b0;
    logic [3:0]  step_ch = '0;
    logic [15:0] armed;
    logic [3:0]  cfg_ch = '0;
    logic [23:0] cfg_addr;
    logic [15:0] cfg_count;
    logic [15:0] cfg_port;
    logic [7:0]  cfg_mode;
    logic        cfg_masked;

    always #5 clk = ~clk;

    dma_cmd_regfile #(.NCH(NCH)) u_dma_cmd_regfile (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .exe_we(exe_we), .exe_wbyte(exe_wbyte), .exe_re(exe_re),
        .exe_rbyte(exe_rbyte), .step_en(step_en), .step_ch(step_ch),
        .armed(armed), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_port(cfg_port), .cfg_mode(cfg_mode),
        .cfg_masked(cfg_masked)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    int m_addr [16];
    int m_cnt  [16];
    int m_port [16];
    int m_mode [16];
    bit m_mask [16];
    int m_op, m_ch, m_ptr;

    function automatic int want_bytes(int op);
        case (op)
            0, 4, 5: return 2;
            2, 3:    return 3;
            7:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_armed(int c);
        return !m_mask[c] && m_mode[c][2];
    endfunction

    function automatic int exp_rbyte();
        if (m_op == 3 && m_ptr < 3) return (m_addr[m_ch] >> (8 * m_ptr)) & 255;
        if (m_op == 5 && m_ptr < 2) return (m_cnt[m_ch] >> (8 * m_ptr)) & 255;
        return 0;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 16; c++) begin
            m_addr[c] = 0; m_cnt[c] = 0; m_port[c] = 0; m_mode[c] = 0; m_mask[c] = 1;
        end
        m_op = 15; m_ch = 0; m_ptr = 0;
    endtask

    task automatic model_step(bit c_we, int c_b, bit x_we, int x_b, bit x_re,
                              bit s_en, int s_ch);
        bit was_armed;
        int sh;
        was_armed = m_armed(s_ch);
        if (c_we) begin
            m_op = c_b >> 4; m_ch = c_b & 15; m_ptr = 0;
            if (m_op == 9)  m_mask[m_ch] = 1;
            if (m_op == 10) m_mask[m_ch] = 0;
        end else if (x_we) begin
            if ((m_op == 0 || m_op == 2 || m_op == 4 || m_op == 7) && m_ptr < want_bytes(m_op)) begin
                sh = 8 * m_ptr;
                case (m_op)
                    0: m_port[m_ch] = (m_port[m_ch] & ~(255 << sh)) | (x_b << sh);
                    2: m_addr[m_ch] = (m_addr[m_ch] & ~(255 << sh)) | (x_b << sh);
                    4: m_cnt[m_ch]  = (m_cnt[m_ch]  & ~(255 << sh)) | (x_b << sh);
                    default: m_mode[m_ch] = x_b;
                endcase
                m_ptr++;
            end
        end else if (x_re) begin
            if ((m_op == 3 || m_op == 5) && m_ptr < want_bytes(m_op)) m_ptr++;
        end
        if (s_en && !c_we && !x_we && was_armed && m_cnt[s_ch] != 0) begin
            m_cnt[s_ch]  = m_cnt[s_ch] - 1;
            m_addr[s_ch] = (m_addr[s_ch] + (m_mode[s_ch][6] ? 2 : 1)) & 24'hFFFFFF;
        end
    endtask

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_view(string tag);
        int c;
        logic [15:0] ea;
        c = cfg_ch;
        for (int k = 0; k < 16; k++) ea[k] = m_armed(k);
        check(tag, "addr",   cfg_addr,   m_addr[c]);
        check(tag, "count",  cfg_count,  m_cnt[c]);
        check(tag, "port",   cfg_port,   m_port[c]);
        check(tag, "mode",   cfg_mode,   m_mode[c]);
        check(tag, "masked", cfg_masked, m_mask[c]);
        check("R6", "armed", armed, ea);
    endtask

    // One clock: drive at the falling edge, check read byte, then state after the edge.
    task automatic tick(bit c_we, int c_b, bit x_we, int x_b, bit x_re,
                        bit s_en, int s_ch, string tag);
        cmd_we = c_we; cmd_byte = 8'(c_b); exe_we = x_we; exe_wbyte = 8'(x_b);
        exe_re = x_re; step_en = s_en; step_ch = 4'(s_ch);
        #1;
        check("R8", "exe_rbyte", exe_rbyte, exp_rbyte());
        @(posedge clk);
        model_step(c_we, c_b, x_we, x_b, x_re, s_en, s_ch);
        #1;
        check_view(tag);
        @(negedge clk);
    endtask

    task automatic cmd(int b, string tag);  tick(1, b, 0, 0, 0, 0, 0, tag); endtask
    task automatic wr(int b, string tag);   tick(0, 0, 1, b, 0, 0, 0, tag); endtask
    task automatic rd(string tag);          tick(0, 0, 0, 0, 1, 0, 0, tag); endtask
    task automatic step(int c, string tag); tick(0, 0, 0, 0, 0, 1, c, tag); endtask
    task automatic idle(string tag);        tick(0, 0, 0, 0, 0, 0, 0, tag); endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int ops [9];
        ops = '{8'h00, 8'h20, 8'h30, 8'h40, 8'h50, 8'h70, 8'h90, 8'hA0, 8'hF0};
        model_reset();
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on several channels, and execute writes with no command.
        cfg_ch = 0;  idle("R1");
        cfg_ch = 15; idle("R1");
        cfg_ch = 5;  wr(8'h77, "R1");

        // Canonical sequence on channel 3: mask, mode, address, count, unmask.
        cfg_ch = 3;
        cmd(8'h93, "R2");
        cmd(8'h73, "R6"); wr(8'h4C, "R6");
        cmd(8'h23, "R3"); wr(8'h56, "R3"); wr(8'h34, "R3"); wr(8'h12, "R3");
        wr(8'hEE, "R7");
        cmd(8'h43, "R4"); wr(8'hFF, "R4"); wr(8'h00, "R4"); wr(8'hAB, "R7");
        cmd(8'hA3, "R2");
        // Read-back with extra reads past the end.
        cmd(8'h33, "R8"); rd("R8"); rd("R8"); rd("R8"); rd("R8");
        cmd(8'h53, "R8"); rd("R8"); rd("R8"); rd("R8");
        wr(8'h99, "R7");
        // I/O port load, plus a surplus byte.
        cmd(8'h03, "R5"); wr(8'h78, "R5"); wr(8'h56, "R5"); wr(8'h11, "R7");
        // Reissued command restarts the pointer mid-load.
        cmd(8'h23, "R7"); wr(8'h11, "R7");
        cmd(8'h23, "R7"); wr(8'h22, "R7"); wr(8'h33, "R7"); wr(8'h44, "R7");
        // 16-bit steps on channel 3.
        for (int k = 0; k < 5; k++) step(3, "R9");
        cmd(8'h33, "R8"); rd("R8"); rd("R8");

        // Channel 5: 8-bit mode, count 2, address about to wrap.
        cfg_ch = 5;
        cmd(8'h95, "R2"); cmd(8'h75, "R6"); wr(8'h04, "R6");
        cmd(8'h25, "R3"); wr(8'hFE, "R3"); wr(8'hFF, "R3"); wr(8'hFF, "R3");
        cmd(8'h45, "R4"); wr(8'h02, "R4"); wr(8'h00, "R4");
        step(5, "R9");
        cmd(8'hA5, "R2");
        for (int k = 0; k < 4; k++) step(5, "R9");
        // Masked channel does not move; step during a command is ignored.
        cmd(8'h45, "R4"); wr(8'h05, "R4");
        cmd(8'h95, "R9"); step(5, "R9");
        cmd(8'hA5, "R9");
        tick(1, 8'h35, 0, 0, 0, 1, 5, "R9");
        tick(0, 0, 1, 8'h01, 0, 1, 5, "R9");
        step(7, "R9");
        // Disarm by clearing the enable bit.
        cmd(8'h75, "R6"); wr(8'h40, "R6"); step(5, "R9");
        // Other channel untouched by channel 5 programming.
        cfg_ch = 3; idle("R10");
        cfg_ch = 4; idle("R10");
        // Unassigned opcode: execute writes ignored.
        cfg_ch = 2; cmd(8'hF2, "R7"); wr(8'h55, "R7"); rd("R7");

        // Pseudo-random phase.
        seed = 32'h1234_5678;
        for (int n = 0; n < 600; n++) begin
            int r, sel;
            seed = seed * 1103515245 + 12345;
            r = int'(seed >> 8);
            cfg_ch = 4'(r >> 20);
            sel = r & 7;
            if (sel == 0)
                tick(1, ops[(r >> 4) % 9] | ((r >> 12) & 3), 0, 0, 0, (r >> 3) & 1, (r >> 12) & 3, "R10");
            else if (sel < 4)
                tick(0, 0, 1, (r >> 4) & 255, (r >> 14) & 1, (r >> 3) & 1, (r >> 12) & 3, "R10");
            else if (sel < 6)
                tick(0, 0, 0, 0, 1, (r >> 3) & 1, (r >> 12) & 3, "R8");
            else
                tick(0, 0, 0, 0, 0, 1, (r >> 12) & 3, "R9");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule